// File: doc/BRIEF.md
# Video frame header parser

This block watches the byte stream that a gigabit receive PHY delivers on its 125 MHz receive clock: one 8-bit byte per cycle, qualified by a data-valid strobe. Each video frame is 780 bytes long. It opens with a fixed four-byte signature, followed by two control bytes. Next come 768 pixel bytes, which are 256 columns of three-byte RGB pixels. It closes with six tail bytes. The parser finds the signature, moves the two control bytes into registers of their own, and drives a write enable that covers only the 768 pixel bytes. A pixel buffer placed after it therefore stores image bytes and nothing else.

Before any pixel is written, the parser issues a one-cycle buffer reset pulse, so that nothing from the previous frame survives in the buffer. It marks the first pixel with a start pulse and the final tail byte with an end pulse. It raises an error pulse when a partly matched signature breaks, or when the valid strobe falls inside a frame. Every output is registered and follows the input byte that causes it by one clock.

Top module: `rx_frame_parser`

## Requirements
- R1: While searching, the valid bytes 0x7C, 0xD2, 0x15, 0xD8 received in that order on consecutive cycles lock the parser. `bufReset` is then high for exactly one cycle, in the cycle after the 0xD8 byte is sampled.
- R2: If a valid byte breaks a partly matched signature, `frameErr` pulses for one cycle. The same byte is then re-examined as a possible first signature byte (0x7C), so a frame that begins on that byte is still found.
- R3: The first and second valid bytes after the signature are stored in `ctrlByte0` and `ctrlByte1`. `ctrlValid` goes high in the cycle after the second control byte is sampled. It stays high, with both registers stable, until the next complete signature, which clears it in the same cycle as `bufReset`.
- R4: `bufWrEn` is high for exactly one cycle per pixel byte, 768 cycles per complete frame, each time one cycle after that byte is sampled. `bufWrData` then carries that byte. `bufWrEn` is never high for signature, control or tail bytes.
- R5: `payloadStart` pulses once per frame, in the same cycle as the first `bufWrEn`.
- R6: After the six tail bytes, `frameEnd` pulses once, in the cycle after the 780th byte and six cycles after the last write. The parser then searches again and accepts a following frame that starts on the very next cycle. The values of the tail bytes are not examined.
- R7: `bufReset` comes exactly three cycles before the first `bufWrEn` of the same frame.
- R8: If `rxValid` is low in any cycle after the first signature byte and before the 780th byte, `frameErr` pulses once in the following cycle, no further writes occur, and the parser returns to searching.
- R9: While `rstN` is low, all pulse outputs, `bufWrEn`, `ctrlValid` and both control registers are zero. An asserted reset abandons any frame in progress.
- R10: While the parser is searching, bytes with `rxValid` low have no effect, even when they carry signature values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Receive byte qualifier |
| rxData | input | 8 | Receive byte |
| bufReset | output | 1 | One-cycle clear pulse for the pixel buffer |
| bufWrEn | output | 1 | Pixel buffer write enable |
| bufWrData | output | 8 | Pixel byte to write |
| payloadStart | output | 1 | Pulse with the first pixel write |
| frameEnd | output | 1 | Pulse after the last tail byte |
| frameErr | output | 1 | Pulse on a broken signature or a truncated frame |
| ctrlValid | output | 1 | Control registers hold the current frame's values |
| ctrlByte0 | output | 8 | First control byte |
| ctrlByte1 | output | 8 | Second control byte |

## Verification
The parser keeps a single state and a single position counter. A wrong counter value appears at the ports only late: it shifts `frameEnd` away from its fixed distance of six cycles after the last write, or it makes the write count differ from 768, and neither shows until the end of the frame, up to 780 cycles later. A wrong state value shows at once. A missed lock leaves no `bufReset` in the cycle after 0xD8. A failed return to searching leaves `frameErr` silent when valid falls, or makes the frame that follows go unseen. Pixel bytes are numbered in a known sequence so that a write slipped by one byte shows as wrong data on the very first write.

// File: rtl/rx_frame_pkg.sv
`timescale 1ns/100ps
package rx_frame_pkg;
  localparam int BYTE_W   = 8;
  localparam int CTRL_LEN = 2;
  localparam int CTRL_IW  = (CTRL_LEN > 1) ? $clog2(CTRL_LEN) : 1;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_HDR,
    ST_CTRL,
    ST_PAY,
    ST_TAIL
  } parse_state_e;

  // per-byte strobes from the control FSM to the datapath
  typedef struct packed {
    logic               hdrDone;
    logic               ctrlCap;
    logic [CTRL_IW-1:0] ctrlSel;
    logic               payWr;
    logic               payFirst;
    logic               frmEnd;
    logic               frmErr;
  } parse_strobe_t;
endpackage

// File: rtl/rx_frame_sigcmp.sv
`timescale 1ns/100ps
module rx_frame_sigcmp #(
  parameter int                    HDR_LEN   = 4,
  parameter logic [HDR_LEN*8-1:0]  SIGNATURE = 32'h7CD215D8
) (
  input  logic [7:0]         rxData,
  output logic [HDR_LEN-1:0] matchVec
);
  // first signature byte lives in the most significant position
  for (genvar i = 0; i < HDR_LEN; i++) begin : g_cmp
    localparam int SHIFT = (HDR_LEN - 1 - i) * 8;
    assign matchVec[i] = (rxData == SIGNATURE[SHIFT +: 8]);
  end
endmodule

// File: rtl/rx_frame_ctrl.sv
`timescale 1ns/100ps
module rx_frame_ctrl
  import rx_frame_pkg::*;
#(
  parameter int HDR_LEN  = 4,
  parameter int PAY_LEN  = 768,
  parameter int TAIL_LEN = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxValid,
  input  logic [HDR_LEN-1:0] matchVec,
  output parse_strobe_t      strb
);
  localparam int MAX_LEN = (PAY_LEN > HDR_LEN) ? PAY_LEN : HDR_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int HIW     = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;

  parse_state_e     state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             hdrHit;

  assign hdrHit = matchVec[cnt[HIW-1:0]];

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strb     = '0;
    unique case (state)
      ST_SEARCH: begin
        if (rxValid && matchVec[0]) begin
          stateNxt = ST_HDR;
          cntNxt   = CNT_W'(1);
        end
      end
      ST_HDR: begin
        if (!rxValid) begin
          strb.frmErr = 1'b1;
          stateNxt    = ST_SEARCH;
          cntNxt      = '0;
        end else if (hdrHit) begin
          if (cnt == CNT_W'(HDR_LEN - 1)) begin
            strb.hdrDone = 1'b1;
            stateNxt     = ST_CTRL;
            cntNxt       = '0;
          end else begin
            cntNxt = cnt + CNT_W'(1);
          end
        end else begin
          // broken signature: flag it and retry this byte as a new start
          strb.frmErr = 1'b1;
          if (matchVec[0]) begin
            stateNxt = ST_HDR;
            cntNxt   = CNT_W'(1);
          end else begin
            stateNxt = ST_SEARCH;
            cntNxt   = '0;
          end
        end
      end
      ST_CTRL: begin
        if (!rxValid) begin
          strb.frmErr = 1'b1;
          stateNxt    = ST_SEARCH;
          cntNxt      = '0;
        end else begin
          strb.ctrlCap = 1'b1;
          strb.ctrlSel = cnt[CTRL_IW-1:0];
          if (cnt == CNT_W'(CTRL_LEN - 1)) begin
            stateNxt = ST_PAY;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + CNT_W'(1);
          end
        end
      end
      ST_PAY: begin
        if (!rxValid) begin
          strb.frmErr = 1'b1;
          stateNxt    = ST_SEARCH;
          cntNxt      = '0;
        end else begin
          strb.payWr    = 1'b1;
          strb.payFirst = (cnt == '0);
          if (cnt == CNT_W'(PAY_LEN - 1)) begin
            stateNxt = ST_TAIL;
            cntNxt   = '0;
          end else begin
            cntNxt = cnt + CNT_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (!rxValid) begin
          strb.frmErr = 1'b1;
          stateNxt    = ST_SEARCH;
          cntNxt      = '0;
        end else if (cnt == CNT_W'(TAIL_LEN - 1)) begin
          strb.frmEnd = 1'b1;
          stateNxt    = ST_SEARCH;
          cntNxt      = '0;
        end else begin
          cntNxt = cnt + CNT_W'(1);
        end
      end
      default: begin
        stateNxt = ST_SEARCH;
        cntNxt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_SEARCH;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end
endmodule

// File: rtl/rx_frame_dpath.sv
`timescale 1ns/100ps
module rx_frame_dpath
  import rx_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   rxData,
  input  parse_strobe_t       strb,
  output logic                bufReset,
  output logic                bufWrEn,
  output logic [BYTE_W-1:0]   bufWrData,
  output logic                payloadStart,
  output logic                frameEnd,
  output logic                frameErr,
  output logic                ctrlValid,
  output logic [BYTE_W-1:0]   ctrlByte0,
  output logic [BYTE_W-1:0]   ctrlByte1
);
  logic [BYTE_W-1:0] ctrlReg [CTRL_LEN];

  for (genvar i = 0; i < CTRL_LEN; i++) begin : g_ctrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrlReg[i] <= '0;
      else if (strb.ctrlCap && (strb.ctrlSel == CTRL_IW'(i)))
        ctrlReg[i] <= rxData;
    end
  end

  assign ctrlByte0 = ctrlReg[0];
  assign ctrlByte1 = ctrlReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReset     <= 1'b0;
      bufWrEn      <= 1'b0;
      bufWrData    <= '0;
      payloadStart <= 1'b0;
      frameEnd     <= 1'b0;
      frameErr     <= 1'b0;
      ctrlValid    <= 1'b0;
    end else begin
      bufReset     <= strb.hdrDone;
      bufWrEn      <= strb.payWr;
      payloadStart <= strb.payFirst;
      frameEnd     <= strb.frmEnd;
      frameErr     <= strb.frmErr;
      if (strb.payWr)
        bufWrData <= rxData;
      if (strb.hdrDone)
        ctrlValid <= 1'b0;
      else if (strb.ctrlCap && (strb.ctrlSel == CTRL_IW'(CTRL_LEN - 1)))
        ctrlValid <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_parser.sv
`timescale 1ns/100ps
module rx_frame_parser
  import rx_frame_pkg::*;
#(
  parameter int                   HDR_LEN   = 4,
  parameter logic [HDR_LEN*8-1:0] SIGNATURE = 32'h7CD215D8,
  parameter int                   PAY_LEN   = 768,
  parameter int                   TAIL_LEN  = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  output logic       bufReset,
  output logic       bufWrEn,
  output logic [7:0] bufWrData,
  output logic       payloadStart,
  output logic       frameEnd,
  output logic       frameErr,
  output logic       ctrlValid,
  output logic [7:0] ctrlByte0,
  output logic [7:0] ctrlByte1
);
  logic [HDR_LEN-1:0] matchVec;
  parse_strobe_t      strb;

  rx_frame_sigcmp #(
    .HDR_LEN  (HDR_LEN),
    .SIGNATURE(SIGNATURE)
  ) u_sigcmp (
    .rxData  (rxData),
    .matchVec(matchVec)
  );

  rx_frame_ctrl #(
    .HDR_LEN (HDR_LEN),
    .PAY_LEN (PAY_LEN),
    .TAIL_LEN(TAIL_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .matchVec(matchVec),
    .strb    (strb)
  );

  rx_frame_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .rxData      (rxData),
    .strb        (strb),
    .bufReset    (bufReset),
    .bufWrEn     (bufWrEn),
    .bufWrData   (bufWrData),
    .payloadStart(payloadStart),
    .frameEnd    (frameEnd),
    .frameErr    (frameErr),
    .ctrlValid   (ctrlValid),
    .ctrlByte0   (ctrlByte0),
    .ctrlByte1   (ctrlByte1)
  );
endmodule

// File: rtl/rx_frame_parser_chk.sv
`timescale 1ns/100ps
module rx_frame_parser_chk #(
  parameter int PAY_LEN = 768
) (
  input logic       clk,
  input logic       rstN,
  input logic       rxValid,
  input logic       bufReset,
  input logic       bufWrEn,
  input logic       payloadStart,
  input logic       frameEnd,
  input logic       frameErr,
  input logic       ctrlValid,
  input logic [7:0] ctrlByte0,
  input logic [7:0] ctrlByte1
);
  localparam int WC_W = $clog2(PAY_LEN + 2);
  logic [WC_W-1:0] wrSinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      wrSinceRst <= '0;
    else if (bufReset)
      wrSinceRst <= '0;
    else if (bufWrEn)
      wrSinceRst <= wrSinceRst + WC_W'(1);
  end

  // R4
  wr_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (wrSinceRst < WC_W'(PAY_LEN)));

  // R4
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !bufWrEn);

  // R5
  start_with_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    payloadStart |-> bufWrEn);

  // R7
  reset_lead_chk: assert property (@(posedge clk) disable iff (!rstN)
    payloadStart |-> $past(bufReset, 3));

  // R1
  reset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufReset |=> !bufReset);

  // R6
  end_after_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ($past(bufWrEn, 6) && !$past(bufWrEn, 5) && !bufWrEn));

  // R8
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> !bufWrEn);

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && $past(ctrlValid)) |-> ($stable(ctrlByte0) && $stable(ctrlByte1)));

  // R3
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufReset |-> !ctrlValid);
endmodule

bind rx_frame_parser rx_frame_parser_chk #(.PAY_LEN(PAY_LEN)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rxValid     (rxValid),
  .bufReset    (bufReset),
  .bufWrEn     (bufWrEn),
  .payloadStart(payloadStart),
  .frameEnd    (frameEnd),
  .frameErr    (frameErr),
  .ctrlValid   (ctrlValid),
  .ctrlByte0   (ctrlByte0),
  .ctrlByte1   (ctrlByte1)
);

// File: tb/rx_frame_parser_tb.sv
`timescale 1ns/100ps
module rx_frame_parser_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       bufReset, bufWrEn, payloadStart, frameEnd, frameErr, ctrlValid;
  logic [7:0] bufWrData, ctrlByte0, ctrlByte1;

  localparam logic [31:0] SIG = 32'h7CD215D8;

  always #2.5 clk = ~clk;

  rx_frame_parser u_dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .bufReset(bufReset), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .payloadStart(payloadStart), .frameEnd(frameEnd), .frameErr(frameErr),
    .ctrlValid(ctrlValid), .ctrlByte0(ctrlByte0), .ctrlByte1(ctrlByte1)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // port monitor, sampled at the falling edge
  logic monClr = 1'b0;
  int   seed = 0;
  int   wrCnt, sopCnt, endCnt, errCnt, rstCnt, dataBad, cvAtRst;
  int   firstWrCyc, lastWrCyc, sopCyc, endCyc, rstCyc, cvRiseCyc;
  logic prevCv = 1'b0;

  always @(negedge clk) begin
    if (monClr) begin
      wrCnt = 0; sopCnt = 0; endCnt = 0; errCnt = 0; rstCnt = 0;
      dataBad = 0; cvAtRst = 0; firstWrCyc = 0; lastWrCyc = 0;
      sopCyc = 0; endCyc = 0; rstCyc = 0; cvRiseCyc = 0;
    end else begin
      if (bufWrEn === 1'b1) begin
        if (wrCnt == 0) firstWrCyc = cyc;
        if (bufWrData !== 8'(wrCnt + seed)) dataBad++;
        wrCnt++;
        lastWrCyc = cyc;
      end
      if (payloadStart === 1'b1) begin sopCnt++; sopCyc = cyc; end
      if (frameEnd === 1'b1) begin endCnt++; endCyc = cyc; end
      if (frameErr === 1'b1) errCnt++;
      if (bufReset === 1'b1) begin
        rstCnt++; rstCyc = cyc;
        if (ctrlValid !== 1'b0) cvAtRst++;
      end
      if (ctrlValid === 1'b1 && prevCv !== 1'b1) cvRiseCyc = cyc;
    end
    prevCv = ctrlValid;
  end

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = d;
  endtask

  // idle cycles drive a signature byte with valid low
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rxValid = 1'b0;
      rxData  = 8'h7C;
    end
  endtask

  task automatic clearMon();
    @(posedge clk); monClr = 1'b1;
    @(posedge clk); monClr = 1'b0;
  endtask

  // cut = number of frame bytes sent before valid drops, 0 = whole frame
  task automatic sendFrame(input logic [7:0] c0, input logic [7:0] c1,
                           input int sd, input int cut);
    int n;
    n = (cut == 0) ? 780 : cut;
    for (int k = 0; k < n; k++) begin
      if (k < 4)        sendByte(SIG[(3 - k) * 8 +: 8]);
      else if (k == 4)  sendByte(c0);
      else if (k == 5)  sendByte(c1);
      else if (k < 774) sendByte(8'(k - 6 + sd));
      else              sendByte(8'h00);
    end
  endtask

  // pre: 0 none, 1 bytes 7C D2 00, 2 byte 7C, 3 bytes 11 22 D8
  typedef struct packed {
    logic [1:0] pre;
    logic [7:0] c0;
    logic [7:0] c1;
    logic [9:0] cut;
    logic [7:0] seed;
    logic [9:0] expWr;
    logic       expErr;
    logic       expEnd;
    logic       expRst;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h00, 8'h34, 10'd0,   8'd0,   10'd768, 1'b0, 1'b1, 1'b1},
    '{2'd1, 8'h12, 8'hAB, 10'd0,   8'd5,   10'd768, 1'b1, 1'b1, 1'b1},
    '{2'd2, 8'h35, 8'h34, 10'd0,   8'd200, 10'd768, 1'b1, 1'b1, 1'b1},
    '{2'd3, 8'hFF, 8'h00, 10'd0,   8'd9,   10'd768, 1'b0, 1'b1, 1'b1},
    '{2'd0, 8'h00, 8'h00, 10'd3,   8'd0,   10'd0,   1'b1, 1'b0, 1'b0},
    '{2'd0, 8'h00, 8'h00, 10'd5,   8'd0,   10'd0,   1'b1, 1'b0, 1'b1},
    '{2'd0, 8'h00, 8'h00, 10'd100, 8'd1,   10'd94,  1'b1, 1'b0, 1'b1},
    '{2'd0, 8'h00, 8'h00, 10'd774, 8'd7,   10'd768, 1'b1, 1'b0, 1'b1},
    '{2'd0, 8'h00, 8'h00, 10'd779, 8'd2,   10'd768, 1'b1, 1'b0, 1'b1}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    // R9: outputs held low during reset
    repeat (3) @(negedge clk);
    checkEq("R9 bufReset", int'(bufReset), 0);
    checkEq("R9 bufWrEn", int'(bufWrEn), 0);
    checkEq("R9 pulses", int'(payloadStart | frameEnd | frameErr), 0);
    checkEq("R9 ctrlValid", int'(ctrlValid), 0);
    checkEq("R9 ctrlByte0", int'(ctrlByte0), 0);
    checkEq("R9 ctrlByte1", int'(ctrlByte1), 0);
    rstN = 1'b1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      clearMon();
      seed = int'(v.seed);
      case (v.pre)
        2'd1: begin sendByte(8'h7C); sendByte(8'hD2); sendByte(8'h00); end
        2'd2: sendByte(8'h7C);
        2'd3: begin sendByte(8'h11); sendByte(8'h22); sendByte(8'hD8); end
        default: ;
      endcase
      sendFrame(v.c0, v.c1, int'(v.seed), int'(v.cut));
      idle(4);
      checkEq("R4 write count", wrCnt, int'(v.expWr));
      checkEq("R4 write data", dataBad, 0);
      checkEq("R5 start count", sopCnt, (v.expWr != 0) ? 1 : 0);
      checkEq("R6 end count", endCnt, int'(v.expEnd));
      checkEq((v.cut != 0) ? "R8 error count" : "R2 error count", errCnt, int'(v.expErr));
      checkEq("R1 buffer reset count", rstCnt, int'(v.expRst));
      if (v.expEnd) begin
        checkEq("R3 ctrlByte0", int'(ctrlByte0), int'(v.c0));
        checkEq("R3 ctrlByte1", int'(ctrlByte1), int'(v.c1));
        checkEq("R3 ctrlValid held", int'(ctrlValid), 1);
        checkEq("R3 ctrlValid low at lock", cvAtRst, 0);
        checkEq("R3 ctrlValid rise", cvRiseCyc, firstWrCyc - 1);
        checkEq("R7 reset lead", firstWrCyc - rstCyc, 3);
        checkEq("R5 start timing", sopCyc, firstWrCyc);
        checkEq("R6 end timing", endCyc - lastWrCyc, 6);
      end else if (!v.expRst) begin
        checkEq("R3 ctrlValid kept without lock", int'(ctrlValid), 1);
      end else if (v.cut < 6) begin
        checkEq("R3 ctrlValid cleared by lock", int'(ctrlValid), 0);
      end
    end

    // R10: signature bytes with valid low while searching
    clearMon();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rxValid = 1'b0;
      rxData  = SIG[(3 - k) * 8 +: 8];
    end
    idle(4);
    checkEq("R10 no lock on invalid bytes", rstCnt, 0);
    checkEq("R10 no error on invalid bytes", errCnt, 0);
    checkEq("R10 no writes on invalid bytes", wrCnt, 0);

    // R6: two frames back to back without a gap
    clearMon();
    seed = 0;
    sendFrame(8'h01, 8'h02, 0, 0);
    sendFrame(8'h77, 8'h88, 0, 0);
    idle(4);
    checkEq("R6 back-to-back writes", wrCnt, 1536);
    checkEq("R6 back-to-back ends", endCnt, 2);
    checkEq("R6 back-to-back errors", errCnt, 0);
    checkEq("R6 back-to-back data", dataBad, 0);
    checkEq("R3 second frame ctrlByte0", int'(ctrlByte0), 8'h77);

    // R9: reset in the middle of a frame
    clearMon();
    seed = 3;
    sendFrame(8'h44, 8'h55, 3, 50);
    @(negedge clk);
    rstN    = 1'b0;
    rxValid = 1'b0;
    @(negedge clk);
    checkEq("R9 mid-frame bufWrEn", int'(bufWrEn), 0);
    checkEq("R9 mid-frame ctrlValid", int'(ctrlValid), 0);
    checkEq("R9 mid-frame ctrlByte0", int'(ctrlByte0), 0);
    checkEq("R9 mid-frame frameErr", int'(frameErr), 0);
    rstN = 1'b1;
    idle(2);
    clearMon();
    sendFrame(8'h44, 8'h55, 3, 0);
    idle(4);
    checkEq("R9 frame after reset writes", wrCnt, 768);
    checkEq("R9 frame after reset errors", errCnt, 0);
    checkEq("R9 frame after reset data", dataBad, 0);

    summary();
    $finish;
  end
endmodule